// File: doc/BRIEF.md
# Two-State Interrupt Priority Mask Unit

This block works out the current execution priority of a core that runs in a Secure and a Non-secure state, and decides which pending interrupt, if any, may preempt it. Each interrupt has an enable bit, a pending bit, a state bit (Secure or Non-secure) and an 8-bit priority. Both states have their own all-masking flag and their own priority-threshold register. A single fold control decides whether Non-secure priorities are squeezed into the lower-urgency half of the 8-bit space. All of these feed one shared priority scale, so a mask set by either state can hold off interrupts of the other state.

Software reaches every register through a single write port. A registered read port returns the stored values. Only the upper implemented bits of each priority and threshold register are stored, and the low bits read back as zero. The active-handler priority comes from outside the block and is already expressed on the shared scale. Nothing changes a mask on its own: a mask moves only when software writes it. Taking an interrupt does not clear its pending bit, because acknowledging an interrupt is the job of the surrounding logic.

Top module: `prio_mask_unit`

## Requirements
- R1: After synchronous reset, every register reads 0, `take_req` is 0 and `exec_prio` is 9'h100. The value 9'h100 means that no boost is in force.
- R2: Priority and threshold registers keep only the top `PRIO_BITS` bits (default 3, bits [7:5]). The low bits read as 0. A threshold written only into low bits reads back 0 and masks nothing.
- R3: A Non-secure interrupt's stored priority p takes effect as `(p>>1)|8'h80` while the fold bit is 1, and as p while the fold bit is 0. Secure priorities are never changed.
- R4: While the Secure all-mask flag is 1, `exec_prio` is 0 and no interrupt is taken.
- R5: While the Non-secure all-mask flag is 1, `exec_prio` is at most 8'h80 when the fold bit is 1 and at most 8'h00 when it is 0. A Secure interrupt of priority 8'h40 can still be taken under the 8'h80 level.
- R6: With the fold bit at 1, a Secure threshold of 8'h80 holds off every Non-secure interrupt, whatever its stored priority. A Secure interrupt of priority 8'h60 is still taken.
- R7: With the fold bit at 1, a Non-secure threshold b takes effect as `(b>>1)|8'h80`. A threshold of 8'h80 therefore gives level 8'hC0, which blocks a Secure interrupt of priority 8'hC0 but not one of priority 8'hA0.
- R8: `exec_prio` is the minimum of the active-handler priority (when `act_valid` is 1) and every mask level that is in force. A threshold of 0 imposes no level.
- R9: An interrupt is taken only when it is enabled, pending, and its effective priority is strictly below `exec_prio`. The candidate with the lowest effective priority wins. On a tie, the lowest interrupt number wins.
- R10: An interrupt pended while it is masked stays pending, and it is taken once the mask is lowered.
- R11: Register select codes for `wr_sel` and `rd_sel` are: 0 enable, 1 pending, 2 state (1 = Non-secure), 3 priority, 4 Secure all-mask, 5 Non-secure all-mask, 6 Secure threshold, 7 Non-secure threshold, 8 fold. Single-bit registers use data bit 0. Outputs reflect a write two clock edges after the write edge, and `rd_data` is valid one edge after `rd_sel` and `rd_irq` are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_irq | input | IRQ_W | Interrupt index for per-interrupt registers |
| wr_data | input | 8 | Write data |
| rd_sel | input | 4 | Register select for the read |
| rd_irq | input | IRQ_W | Interrupt index for the read |
| rd_data | output | 8 | Registered read data |
| act_valid | input | 1 | A handler is active |
| act_prio | input | 8 | Priority of the active handler on the shared scale |
| take_req | output | 1 | A pending interrupt may preempt |
| take_id | output | IRQ_W | Number of the winning interrupt |
| exec_prio | output | 9 | Current execution priority; 9'h100 means no boost |

## Verification
The assertions assume that `act_prio`, when valid, is already on the shared scale. They also assume that `wr_irq` selects an existing interrupt whenever a per-interrupt register is written. The stimulus writes only indices below `N_IRQ`, and it changes `act_valid`/`act_prio` only at negative edges, so every input is stable across the sampling edge. Each scenario holds its inputs until the two-edge latency has passed before an expectation is queued. As a result, the checks on mask and take behaviour never see a value that is still moving through the pipeline.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [3:0] {
    SEL_ENABLE   = 4'd0,
    SEL_PEND     = 4'd1,
    SEL_STATE    = 4'd2,
    SEL_PRIO     = 4'd3,
    SEL_ALLMSK_S = 4'd4,
    SEL_ALLMSK_N = 4'd5,
    SEL_THRESH_S = 4'd6,
    SEL_THRESH_N = 4'd7,
    SEL_FOLD     = 4'd8
  } reg_sel_e;

  localparam logic [8:0] PRIO_IDLE = 9'h100;

  // Map a Non-secure level into the lower-urgency half of the shared scale.
  function automatic logic [7:0] fold_half(input logic [7:0] p);
    return {1'b1, p[7:1]};
  endfunction

endpackage

// File: rtl/pmu_regs.sv
module pmu_regs #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_BITS = 3,
  parameter int IRQ_W     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [3:0]             wr_sel,
  input  logic [IRQ_W-1:0]       wr_irq,
  input  logic [7:0]             wr_data,
  input  logic [3:0]             rd_sel,
  input  logic [IRQ_W-1:0]       rd_irq,
  output logic [7:0]             rd_data,
  output logic [N_IRQ-1:0]       en_q,
  output logic [N_IRQ-1:0]       pend_q,
  output logic [N_IRQ-1:0]       ns_q,
  output logic [N_IRQ*8-1:0]     prio_flat,
  output logic                   allmsk_s_q,
  output logic                   allmsk_n_q,
  output logic [7:0]             thr_s_q,
  output logic [7:0]             thr_n_q,
  output logic                   fold_q
);
  import pmu_pkg::*;

  localparam int LOW_BITS = 8 - PRIO_BITS;

  logic [PRIO_BITS-1:0] prio_hi [N_IRQ];
  logic [PRIO_BITS-1:0] thr_s_hi, thr_n_hi;
  logic                 wr_idx_ok;
  logic [7:0]           rd_next;

  assign wr_idx_ok = (int'(wr_irq) < N_IRQ);
  assign thr_s_q   = {thr_s_hi, {LOW_BITS{1'b0}}};
  assign thr_n_q   = {thr_n_hi, {LOW_BITS{1'b0}}};

  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_prio
      assign prio_flat[g*8 +: 8] = {prio_hi[g], {LOW_BITS{1'b0}}};

      always_ff @(posedge clk) begin
        if (rst) begin
          prio_hi[g] <= '0;
          en_q[g]    <= 1'b0;
          pend_q[g]  <= 1'b0;
          ns_q[g]    <= 1'b0;
        end else if (wr_en && wr_idx_ok && int'(wr_irq) == g) begin
          case (reg_sel_e'(wr_sel))
            SEL_ENABLE: en_q[g]    <= wr_data[0];
            SEL_PEND:   pend_q[g]  <= wr_data[0];
            SEL_STATE:  ns_q[g]    <= wr_data[0];
            SEL_PRIO:   prio_hi[g] <= wr_data[7 -: PRIO_BITS];
            default: ;
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      allmsk_s_q <= 1'b0;
      allmsk_n_q <= 1'b0;
      thr_s_hi   <= '0;
      thr_n_hi   <= '0;
      fold_q     <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_ALLMSK_S: allmsk_s_q <= wr_data[0];
        SEL_ALLMSK_N: allmsk_n_q <= wr_data[0];
        SEL_THRESH_S: thr_s_hi   <= wr_data[7 -: PRIO_BITS];
        SEL_THRESH_N: thr_n_hi   <= wr_data[7 -: PRIO_BITS];
        SEL_FOLD:     fold_q     <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = 8'h00;
    if (int'(rd_irq) < N_IRQ) begin
      case (reg_sel_e'(rd_sel))
        SEL_ENABLE: rd_next = {7'd0, en_q[rd_irq]};
        SEL_PEND:   rd_next = {7'd0, pend_q[rd_irq]};
        SEL_STATE:  rd_next = {7'd0, ns_q[rd_irq]};
        SEL_PRIO:   rd_next = prio_flat[rd_irq*8 +: 8];
        default: ;
      endcase
    end
    case (reg_sel_e'(rd_sel))
      SEL_ALLMSK_S: rd_next = {7'd0, allmsk_s_q};
      SEL_ALLMSK_N: rd_next = {7'd0, allmsk_n_q};
      SEL_THRESH_S: rd_next = thr_s_q;
      SEL_THRESH_N: rd_next = thr_n_q;
      SEL_FOLD:     rd_next = {7'd0, fold_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/pmu_exec.sv
module pmu_exec (
  input  logic       act_valid,
  input  logic [7:0] act_prio,
  input  logic       allmsk_s,
  input  logic       allmsk_n,
  input  logic [7:0] thr_s,
  input  logic [7:0] thr_n,
  input  logic       fold,
  output logic [8:0] level
);
  import pmu_pkg::*;

  logic [7:0] thr_n_eff;
  logic [8:0] allmsk_n_lvl;

  assign thr_n_eff    = fold ? fold_half(thr_n) : thr_n;
  assign allmsk_n_lvl = fold ? 9'h080 : 9'h000;

  always_comb begin
    level = act_valid ? {1'b0, act_prio} : PRIO_IDLE;
    if (thr_s != 8'h00 && {1'b0, thr_s} < level)
      level = {1'b0, thr_s};
    if (thr_n != 8'h00 && {1'b0, thr_n_eff} < level)
      level = {1'b0, thr_n_eff};
    if (allmsk_n && allmsk_n_lvl < level)
      level = allmsk_n_lvl;
    if (allmsk_s)
      level = 9'h000;
  end

endmodule

// File: rtl/pmu_arb.sv
module pmu_arb #(
  parameter int N_IRQ = 8,
  parameter int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0]   en,
  input  logic [N_IRQ-1:0]   pend,
  input  logic [N_IRQ-1:0]   ns,
  input  logic [N_IRQ*8-1:0] prio_flat,
  input  logic               fold,
  input  logic [8:0]         level,
  output logic               take,
  output logic [IRQ_W-1:0]   win_id
);
  import pmu_pkg::*;

  logic [7:0]       eff [N_IRQ];
  logic [N_IRQ-1:0] cand;
  logic [8:0]       best;

  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_eff
      assign eff[g]  = (ns[g] && fold) ? fold_half(prio_flat[g*8 +: 8])
                                       : prio_flat[g*8 +: 8];
      assign cand[g] = en[g] & pend[g];
    end
  endgenerate

  // Strict comparison in ascending order keeps the lowest number on ties.
  always_comb begin
    best   = PRIO_IDLE;
    win_id = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && {1'b0, eff[i]} < best) begin
        best   = {1'b0, eff[i]};
        win_id = IRQ_W'(i);
      end
    end
  end

  assign take = (best != PRIO_IDLE) && (best < level);

endmodule

// File: rtl/prio_mask_unit.sv
module prio_mask_unit #(
  parameter int N_IRQ     = 8,
  parameter int PRIO_BITS = 3,
  parameter int IRQ_W     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [3:0]       wr_sel,
  input  logic [IRQ_W-1:0] wr_irq,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       rd_sel,
  input  logic [IRQ_W-1:0] rd_irq,
  output logic [7:0]       rd_data,
  input  logic             act_valid,
  input  logic [7:0]       act_prio,
  output logic             take_req,
  output logic [IRQ_W-1:0] take_id,
  output logic [8:0]       exec_prio
);
  import pmu_pkg::*;

  logic [N_IRQ-1:0]   en_q, pend_q, ns_q;
  logic [N_IRQ*8-1:0] prio_flat;
  logic               allmsk_s_q, allmsk_n_q, fold_q;
  logic [7:0]         thr_s_q, thr_n_q;
  logic [8:0]         level;
  logic               take_c;
  logic [IRQ_W-1:0]   win_c;

  pmu_regs #(.N_IRQ(N_IRQ), .PRIO_BITS(PRIO_BITS), .IRQ_W(IRQ_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_irq(wr_irq), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_irq(rd_irq), .rd_data(rd_data),
    .en_q(en_q), .pend_q(pend_q), .ns_q(ns_q), .prio_flat(prio_flat),
    .allmsk_s_q(allmsk_s_q), .allmsk_n_q(allmsk_n_q),
    .thr_s_q(thr_s_q), .thr_n_q(thr_n_q), .fold_q(fold_q)
  );

  pmu_exec u_exec (
    .act_valid(act_valid), .act_prio(act_prio),
    .allmsk_s(allmsk_s_q), .allmsk_n(allmsk_n_q),
    .thr_s(thr_s_q), .thr_n(thr_n_q), .fold(fold_q),
    .level(level)
  );

  pmu_arb #(.N_IRQ(N_IRQ), .IRQ_W(IRQ_W)) u_arb (
    .en(en_q), .pend(pend_q), .ns(ns_q), .prio_flat(prio_flat),
    .fold(fold_q), .level(level),
    .take(take_c), .win_id(win_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_req  <= 1'b0;
      take_id   <= '0;
      exec_prio <= PRIO_IDLE;
    end else begin
      take_req  <= take_c;
      take_id   <= take_c ? win_c : '0;
      exec_prio <= level;
    end
  end

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int N_IRQ = 8,
  parameter int IRQ_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [N_IRQ-1:0] en_q,
  input logic [N_IRQ-1:0] pend_q,
  input logic             allmsk_s_q,
  input logic             allmsk_n_q,
  input logic [7:0]       thr_s_q,
  input logic [7:0]       thr_n_q,
  input logic             fold_q,
  input logic             act_valid,
  input logic             take_req,
  input logic [IRQ_W-1:0] take_id,
  input logic [8:0]       exec_prio
);

  // R4: Secure all-mask pins the level at zero one edge later
  assert_secure_allmask_R4: assert property (@(posedge clk) disable iff (rst)
    allmsk_s_q |=> (exec_prio == 9'h000 && !take_req));

  // R5: Non-secure all-mask caps the level at 0x80 under fold
  assert_ns_allmask_cap_R5: assert property (@(posedge clk) disable iff (rst)
    (allmsk_n_q && fold_q) |=> (exec_prio <= 9'h080));

  // R8: nothing in force leaves the level idle
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && !allmsk_s_q && !allmsk_n_q && thr_s_q == 8'h00 && thr_n_q == 8'h00)
      |=> (exec_prio == 9'h100));

  // R9: a take needs some enabled and pending source one edge earlier
  assert_take_has_source_R9: assert property (@(posedge clk) disable iff (rst)
    take_req |-> (($past(en_q) & $past(pend_q)) != '0));

  // R9: nothing can be strictly below level zero
  assert_no_take_at_top_R9: assert property (@(posedge clk) disable iff (rst)
    take_req |-> (exec_prio != 9'h000 && int'(take_id) < N_IRQ));

endmodule

bind prio_mask_unit pmu_checker #(.N_IRQ(N_IRQ), .IRQ_W(IRQ_W)) u_pmu_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .pend_q(pend_q),
  .allmsk_s_q(allmsk_s_q), .allmsk_n_q(allmsk_n_q),
  .thr_s_q(thr_s_q), .thr_n_q(thr_n_q), .fold_q(fold_q),
  .act_valid(act_valid), .take_req(take_req), .take_id(take_id),
  .exec_prio(exec_prio)
);

// File: tb/prio_mask_unit_bench.sv
module prio_mask_unit_bench;

  localparam int N_IRQ = 8;
  localparam int IRQ_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_sel = '0;
  logic [IRQ_W-1:0] wr_irq = '0;
  logic [7:0]       wr_data = '0;
  logic [3:0]       rd_sel = '0;
  logic [IRQ_W-1:0] rd_irq = '0;
  logic [7:0]       rd_data;
  logic             act_valid = 1'b0;
  logic [7:0]       act_prio = '0;
  logic             take_req;
  logic [IRQ_W-1:0] take_id;
  logic [8:0]       exec_prio;

  always #2.5 clk = ~clk;

  prio_mask_unit #(.N_IRQ(N_IRQ), .PRIO_BITS(3)) u_prio_mask_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_irq(wr_irq),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_irq(rd_irq), .rd_data(rd_data),
    .act_valid(act_valid), .act_prio(act_prio), .take_req(take_req),
    .take_id(take_id), .exec_prio(exec_prio)
  );

  typedef struct {
    string req;
    bit    is_rd;
    bit    take;
    int    id;
    int    lvl;
    int    rd;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (it.is_rd) begin
        if (int'(rd_data) != it.rd) begin
          n_bad++;
          $display("FAIL %s: rd_data actual %02h expected %02h", it.req, rd_data, it.rd);
        end
      end else if (take_req != it.take || int'(exec_prio) != it.lvl ||
                   (it.take && int'(take_id) != it.id)) begin
        n_bad++;
        $display("FAIL %s: take/id/level actual %0d/%0d/%03h expected %0d/%0d/%03h",
                 it.req, take_req, take_id, exec_prio, it.take, it.id, it.lvl);
      end
    end
  end

  task automatic wr(input int sel, input int idx, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_irq = IRQ_W'(idx); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit tk, input int id, input int lvl);
    item_t it;
    repeat (2) @(posedge clk);
    it.req = req; it.is_rd = 1'b0; it.take = tk; it.id = id; it.lvl = lvl; it.rd = 0;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_rd(input string req, input int sel, input int idx, input int val);
    item_t it;
    @(negedge clk);
    rd_sel = 4'(sel); rd_irq = IRQ_W'(idx);
    repeat (2) @(posedge clk);
    it.req = req; it.is_rd = 1'b1; it.take = 1'b0; it.id = 0; it.lvl = 0; it.rd = val;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic set_act(input bit v, input int p);
    @(negedge clk);
    act_valid = v; act_prio = 8'(p);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    expect_out("R1 reset outputs", 0, 0, 'h100);
    expect_rd("R1 reset prio", 3, 0, 'h00);
    expect_rd("R1 reset fold", 8, 0, 'h00);
    // R2 low bits
    wr(3, 0, 'h1F);
    expect_rd("R2 prio low bits", 3, 0, 'h00);
    wr(3, 0, 'hFF);
    expect_rd("R2 prio top bits", 3, 0, 'hE0);
    wr(6, 0, 'h10);
    expect_rd("R2 thresh low bits", 6, 0, 'h00);
    // R9 basic take, R11 select codes
    wr(3, 3, 'h60); wr(0, 3, 1); wr(1, 3, 1);
    wr(3, 1, 'h00); wr(0, 1, 1);
    expect_out("R9 enabled pending wins", 1, 3, 'h100);
    expect_out("R2 low-bit threshold masks nothing", 1, 3, 'h100);
    // R4
    wr(4, 0, 1);
    expect_out("R4 secure all-mask", 0, 0, 'h000);
    wr(4, 0, 0);
    // R8
    set_act(1, 'h60);
    expect_out("R8 tie with handler not taken", 0, 0, 'h060);
    set_act(1, 'h80);
    expect_out("R8 handler level 0x80", 1, 3, 'h080);
    wr(6, 0, 'h40);
    expect_out("R8 threshold below handler", 0, 0, 'h040);
    wr(6, 0, 0);
    set_act(0, 0);
    // R9 ties and ordering
    wr(3, 5, 'h60); wr(0, 5, 1); wr(1, 5, 1);
    expect_out("R9 tie lowest number", 1, 3, 'h100);
    wr(3, 5, 'h40);
    expect_out("R9 lower priority value wins", 1, 5, 'h100);
    wr(0, 5, 0);
    expect_out("R9 disabled ignored", 1, 3, 'h100);
    wr(1, 3, 0);
    expect_out("R9 nothing pending", 0, 0, 'h100);
    // R3 fold
    wr(2, 2, 1); wr(3, 2, 'h20); wr(0, 2, 1); wr(1, 2, 1);
    expect_rd("R11 state bit readback", 2, 2, 'h01);
    set_act(1, 'h90);
    expect_out("R3 unfolded ns prio", 1, 2, 'h090);
    wr(8, 0, 1);
    expect_out("R3 folded ns equals level", 0, 0, 'h090);
    set_act(1, 'hA0);
    expect_out("R3 folded ns below level", 1, 2, 'h0A0);
    set_act(0, 0);
    // R5
    wr(5, 0, 1); wr(3, 3, 'h40); wr(1, 3, 1);
    expect_out("R5 ns all-mask folded", 1, 3, 'h080);
    wr(8, 0, 0);
    expect_out("R5 ns all-mask unfolded", 0, 0, 'h000);
    wr(5, 0, 0); wr(8, 0, 1); wr(1, 3, 0);
    // R6 and R10
    wr(3, 2, 'h00); wr(6, 0, 'h80);
    expect_out("R6 secure thresh blocks ns", 0, 0, 'h080);
    expect_rd("R10 pending kept while masked", 1, 2, 'h01);
    wr(3, 3, 'h60); wr(1, 3, 1);
    expect_out("R6 secure 0x60 still taken", 1, 3, 'h080);
    wr(1, 3, 0);
    wr(6, 0, 0);
    expect_out("R10 taken when mask lowered", 1, 2, 'h100);
    // R7
    wr(1, 2, 0);
    wr(7, 0, 'h80); wr(3, 4, 'hC0); wr(0, 4, 1); wr(1, 4, 1);
    expect_out("R7 ns thresh folds to C0", 0, 0, 'h0C0);
    wr(3, 4, 'hA0);
    expect_out("R7 secure A0 taken", 1, 4, 'h0C0);
    wr(8, 0, 0);
    expect_out("R7 unfolded thresh 0x80", 0, 0, 'h080);
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule